// File: doc/BRIEF.md
# Converter Control Register File with Soft-Reset Handshake

This block is the digital control core of a multi-channel data converter. It holds one global configuration word, a bank of per-channel offset words, a bank of per-channel gain words and a bank of channel-setup words. Each setup word packs two 16-bit channel setups. Host access is a plain parallel register bus. Writes take effect on a single-cycle strobe. A read strobe returns data one cycle later on `rdata`, and `rdata` holds that value until the next read strobe. The bus has no back-pressure: every strobe is accepted in the cycle it is seen, so no valid/ready pair is needed.

Software reset takes two steps. Writing 1 to the reset bit puts every register back to its default, raises the reset-pending bit and raises a reset-valid flag. The flag drops once the configuration word has been read. Reset ends only when a later write returns the reset bit to 0. Until then, writes to the data banks are dropped and only the reset bit of a configuration write has any effect. Two registered latch pins drive external logic. When output-latch select is 0, they follow the latch field of the channel setup chosen by the most recent convert strobe. When it is 1, they follow two fixed bits of the configuration word. When guard drive is enabled, pin 0 is released to the guard function and reads 0 here.

Top module: `adc_cfg_ctrl`

## Requirements
- R1: After the hardware reset `rst_n`, the configuration word reads 0x00000000, every offset word reads 0x00000000, every gain word reads 0x01000000, every setup word reads 0x00000000, and `latch_o` is 0. The address map is: 0 configuration, 1–4 offset channels 0–3, 5–8 gain channels 0–3, 9–12 setup words 0–3.
- R2: A write to address 0 with bit 0 set makes every offset, gain and setup word return to its default, and makes the configuration word read 0x00000003 (bit 0 reset-pending, bit 1 reset-valid). All other bits of that write are dropped, and `latch_o`, `short_o`, `guard_o` and `vref_o` go to 0.
- R3: Reset-valid (configuration bit 1) cannot be written by the host. The first configuration read after a soft reset returns it as 1, and any later read returns it as 0.
- R4: While reset is pending, a configuration write with bit 0 clear only clears bit 0, and its other bits are dropped. Once bit 0 is clear, configuration writes load bits 7:2 normally.
- R5: While reset is pending, writes to offset, gain and setup words are ignored, and reads of them return their defaults.
- R6: A read strobe places the addressed word on `rdata` after the next clock edge, and `rdata` keeps that value until the next read strobe. Addresses 13–15 read as 0. Offset, gain and setup words read back exactly what was last written.
- R7: Configuration bits: bit 2 drives `short_o`, bit 3 drives `guard_o`, bit 4 drives `vref_o`, bit 5 is output-latch select, and bits 7:6 are the fixed latch value. Bits 31:8 always read 0.
- R8: With output-latch select 0, a convert strobe `conv_go` captures `conv_sel`, and `latch_o` shows the selected setup's latch field after that same clock edge. Pointer p selects setup word p>>1. An even p uses bits 5:4 of that word and an odd p uses bits 21:20. While `conv_go` is low, changes on `conv_sel` have no effect.
- R9: With output-latch select 1, `latch_o` equals configuration bits 7:6 whatever pointer is selected.
- R10: With guard enabled, `latch_o[0]` is 0 and `latch_o[1]` follows the source chosen by R8/R9.
- R11: `latch_o` is registered. A write that changes its source shows on the pin one clock edge after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| wr_stb | input | 1 | Single-cycle write strobe |
| rd_stb | input | 1 | Single-cycle read strobe |
| addr | input | 4 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, one cycle after `rd_stb` |
| conv_go | input | 1 | Convert strobe that captures the setup pointer |
| conv_sel | input | 3 | Setup pointer |
| latch_o | output | 2 | Registered latch output pins |
| guard_o | output | 1 | Guard drive enable |
| short_o | output | 1 | Input-short control |
| vref_o | output | 1 | Reference capacitor select |

## Verification
The assertions assume that `wr_stb` and `rd_stb` are single-cycle pulses with a stable address, and that the strobes never target two registers at once. They also assume that `conv_sel` only matters in the cycles where `conv_go` is high. The bench drives every input on the falling clock edge and raises one strobe per transaction, so each write or read lands on exactly one rising edge. It sweeps every mapped and unmapped address, every configuration byte with bit 0 clear, and all eight setup pointers. Expected values come from a bench-side model of the register contents.

// File: rtl/adc_cfg_pkg.sv
package adc_cfg_pkg;
  localparam int DW = 32;
  localparam int CFG_BITS = 8;
  // configuration bit positions
  localparam int B_RST   = 0;
  localparam int B_VALID = 1;
  localparam int B_SHORT = 2;
  localparam int B_GUARD = 3;
  localparam int B_VREF  = 4;
  localparam int B_LSEL  = 5;
  localparam int B_LAT   = 6;
  // latch field position inside one 16-bit setup
  localparam int SETUP_W   = 16;
  localparam int SETUP_LAT = 4;

  typedef struct packed {
    logic [1:0] lat;
    logic       lsel;
    logic       vref;
    logic       guard;
    logic       short_en;
  } cfg_fields_t;

  function automatic logic [DW-1:0] cfg_word(cfg_fields_t f, logic valid, logic rst);
    logic [DW-1:0] w;
    w = '0;
    w[B_RST]     = rst;
    w[B_VALID]   = valid;
    w[B_SHORT]   = f.short_en;
    w[B_GUARD]   = f.guard;
    w[B_VREF]    = f.vref;
    w[B_LSEL]    = f.lsel;
    w[B_LAT+1:B_LAT] = f.lat;
    return w;
  endfunction
endpackage

// File: rtl/adc_cfg_reg.sv
module adc_cfg_reg
  import adc_cfg_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_stb,
  input  logic                rd_stb,
  input  logic [AW-1:0]       addr,
  input  logic [CFG_BITS-1:0] wdata_lo,
  output logic                soft_clr,
  output logic                rst_pend,
  output cfg_fields_t         fields,
  output logic [DW-1:0]       word
);
  logic        is_cfg;
  logic        rs_q;
  logic        rv_q;
  cfg_fields_t f_q;

  assign is_cfg   = (addr == '0);
  assign soft_clr = wr_stb && is_cfg && wdata_lo[B_RST];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q <= 1'b0;
      rv_q <= 1'b0;
      f_q  <= '0;
    end else if (soft_clr) begin
      rs_q <= 1'b1;
      rv_q <= 1'b1;
      f_q  <= '0;
    end else begin
      if (wr_stb && is_cfg) begin
        if (rs_q) begin
          rs_q <= 1'b0;
        end else begin
          f_q.short_en <= wdata_lo[B_SHORT];
          f_q.guard    <= wdata_lo[B_GUARD];
          f_q.vref     <= wdata_lo[B_VREF];
          f_q.lsel     <= wdata_lo[B_LSEL];
          f_q.lat      <= wdata_lo[B_LAT+1:B_LAT];
        end
      end
      if (rd_stb && is_cfg) rv_q <= 1'b0;
    end
  end

  assign rst_pend = rs_q;
  assign fields   = f_q;
  assign word     = cfg_word(f_q, rv_q, rs_q);

  p_reset_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    soft_clr |=> (rst_pend && word[B_VALID] && (fields == '0)));
  p_valid_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && is_cfg && !soft_clr) |=> !word[B_VALID]);
  p_valid_no_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !soft_clr |=> !$rose(rv_q));
  p_reset_exit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_pend && wr_stb && is_cfg && !wdata_lo[B_RST]) |=> (!rst_pend && $stable(fields)));
endmodule

// File: rtl/adc_word_bank.sv
module adc_word_bank
  import adc_cfg_pkg::*;
#(
  parameter int            DEPTH = 4,
  parameter int            AW    = 4,
  parameter int            BASE  = 1,
  parameter logic [DW-1:0] INIT  = '0
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       soft_clr,
  input  logic                       lock,
  input  logic                       wr_stb,
  input  logic [AW-1:0]              addr,
  input  logic [DW-1:0]              wdata,
  output logic                       hit_o,
  output logic [$clog2(DEPTH)-1:0]   idx_o,
  output logic [DEPTH-1:0][DW-1:0]   mem_o
);
  localparam int            IDX_W  = $clog2(DEPTH);
  localparam logic [AW-1:0] BASE_A = AW'(BASE);
  localparam logic [AW-1:0] DEP_A  = AW'(DEPTH);

  logic [AW-1:0]            rel;
  logic [DEPTH-1:0][DW-1:0] mem;

  assign rel   = addr - BASE_A;
  assign hit_o = (rel < DEP_A);
  assign idx_o = rel[IDX_W-1:0];

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                             mem[i] <= INIT;
      else if (soft_clr)                                      mem[i] <= INIT;
      else if (wr_stb && hit_o && !lock && idx_o == IDX_W'(i)) mem[i] <= wdata;
    end
  end

  assign mem_o = mem;

  p_locked_write_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && wr_stb && !soft_clr) |=> $stable(mem));
  p_soft_clear_defaults_r2: assert property (@(posedge clk) disable iff (!rst_n)
    soft_clr |=> (mem == {DEPTH{INIT}}));
endmodule

// File: rtl/adc_latch_drv.sv
module adc_latch_drv
  import adc_cfg_pkg::*;
#(
  parameter int NSET = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      soft_clr,
  input  logic [NSET-1:0][1:0]      set_lat,
  input  logic                      conv_go,
  input  logic [$clog2(NSET)-1:0]   conv_sel,
  input  cfg_fields_t               fields,
  output logic [1:0]                latch_o
);
  localparam int PTR_W = $clog2(NSET);

  logic [PTR_W-1:0] ptr_q;
  logic [PTR_W-1:0] sel;
  logic [1:0]       nxt;
  logic [1:0]       pin_q;

  assign sel = conv_go ? conv_sel : ptr_q;

  always_comb begin
    nxt = fields.lsel ? fields.lat : set_lat[sel];
    if (fields.guard) nxt[0] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      pin_q <= '0;
    end else if (soft_clr) begin
      ptr_q <= '0;
      pin_q <= nxt;
    end else begin
      ptr_q <= sel;
      pin_q <= nxt;
    end
  end

  assign latch_o = pin_q;

  p_fixed_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fields.lsel && !fields.guard) |=> (latch_o == $past(fields.lat)));
  p_guard_pin0_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fields.guard |=> (latch_o[0] == 1'b0));
  p_pointer_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!conv_go && !soft_clr) |=> $stable(ptr_q));
endmodule

// File: rtl/adc_cfg_ctrl.sv
module adc_cfg_ctrl
  import adc_cfg_pkg::*;
#(
  parameter int            AW       = 4,
  parameter int            NUM_CH   = 4,
  parameter int            NUM_SREG = 4,
  parameter logic [31:0]   GAIN_DEF = 32'h0100_0000
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_stb,
  input  logic                          rd_stb,
  input  logic [AW-1:0]                 addr,
  input  logic [31:0]                   wdata,
  output logic [31:0]                   rdata,
  input  logic                          conv_go,
  input  logic [$clog2(2*NUM_SREG)-1:0] conv_sel,
  output logic [1:0]                    latch_o,
  output logic                          guard_o,
  output logic                          short_o,
  output logic                          vref_o
);
  localparam int            OFS_BASE  = 1;
  localparam int            GAIN_BASE = OFS_BASE + NUM_CH;
  localparam int            SET_BASE  = GAIN_BASE + NUM_CH;
  localparam int            NSET      = 2 * NUM_SREG;
  localparam int            CH_W      = $clog2(NUM_CH);
  localparam int            SR_W      = $clog2(NUM_SREG);
  localparam logic [AW-1:0] LAST_A    = AW'(SET_BASE + NUM_SREG - 1);

  logic        soft_clr, rst_pend;
  cfg_fields_t fields;
  logic [DW-1:0] cfg_w;

  logic                        ofs_hit, gain_hit, set_hit;
  logic [CH_W-1:0]             ofs_idx, gain_idx;
  logic [SR_W-1:0]             set_idx;
  logic [NUM_CH-1:0][DW-1:0]   ofs_mem, gain_mem;
  logic [NUM_SREG-1:0][DW-1:0] set_mem;
  logic [NSET-1:0][1:0]        set_lat;
  logic [DW-1:0]               rd_nxt;
  logic [DW-1:0]               rdata_q;

  adc_cfg_reg #(.AW(AW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .rd_stb(rd_stb), .addr(addr),
    .wdata_lo(wdata[CFG_BITS-1:0]), .soft_clr(soft_clr), .rst_pend(rst_pend),
    .fields(fields), .word(cfg_w)
  );

  adc_word_bank #(.DEPTH(NUM_CH), .AW(AW), .BASE(OFS_BASE), .INIT('0)) u_ofs (
    .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .lock(rst_pend), .wr_stb(wr_stb),
    .addr(addr), .wdata(wdata), .hit_o(ofs_hit), .idx_o(ofs_idx), .mem_o(ofs_mem)
  );

  adc_word_bank #(.DEPTH(NUM_CH), .AW(AW), .BASE(GAIN_BASE), .INIT(GAIN_DEF)) u_gain (
    .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .lock(rst_pend), .wr_stb(wr_stb),
    .addr(addr), .wdata(wdata), .hit_o(gain_hit), .idx_o(gain_idx), .mem_o(gain_mem)
  );

  adc_word_bank #(.DEPTH(NUM_SREG), .AW(AW), .BASE(SET_BASE), .INIT('0)) u_set (
    .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .lock(rst_pend), .wr_stb(wr_stb),
    .addr(addr), .wdata(wdata), .hit_o(set_hit), .idx_o(set_idx), .mem_o(set_mem)
  );

  // even pointer: lower setup of the word, odd pointer: upper setup
  for (genvar s = 0; s < NUM_SREG; s++) begin : g_lat
    assign set_lat[2*s]   = set_mem[s][SETUP_LAT+1:SETUP_LAT];
    assign set_lat[2*s+1] = set_mem[s][SETUP_W+SETUP_LAT+1:SETUP_W+SETUP_LAT];
  end

  adc_latch_drv #(.NSET(NSET)) u_latch (
    .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .set_lat(set_lat),
    .conv_go(conv_go), .conv_sel(conv_sel), .fields(fields), .latch_o(latch_o)
  );

  always_comb begin
    if (addr == '0)    rd_nxt = cfg_w;
    else if (ofs_hit)  rd_nxt = ofs_mem[ofs_idx];
    else if (gain_hit) rd_nxt = gain_mem[gain_idx];
    else if (set_hit)  rd_nxt = set_mem[set_idx];
    else               rd_nxt = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (rd_stb) rdata_q <= rd_nxt;
  end

  assign rdata   = rdata_q;
  assign guard_o = fields.guard;
  assign short_o = fields.short_en;
  assign vref_o  = fields.vref;

  p_unmapped_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && addr > LAST_A) |=> (rdata == '0));
  p_read_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> $stable(rdata));
  p_high_cfg_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && addr == '0) |=> (rdata[31:8] == 24'h0));
endmodule

// File: tb/tb_adc_cfg_ctrl.sv
module tb_adc_cfg_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_stb = 1'b0, rd_stb = 1'b0, conv_go = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [2:0]  conv_sel = '0;
  logic [31:0] rdata;
  logic [1:0]  latch_o;
  logic        guard_o, short_o, vref_o;

  int total = 0;
  int bad = 0;
  logic [31:0] set_m [4];
  logic [2:0]  ptr_m;
  logic [31:0] rv;

  always #4 clk = ~clk;

  adc_cfg_ctrl dut (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .rd_stb(rd_stb), .addr(addr),
    .wdata(wdata), .rdata(rdata), .conv_go(conv_go), .conv_sel(conv_sel),
    .latch_o(latch_o), .guard_o(guard_o), .short_o(short_o), .vref_o(vref_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    addr = a; rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
    d = rdata;
  endtask

  task automatic conv(input logic [2:0] p);
    conv_sel = p; conv_go = 1'b1;
    @(negedge clk);
    conv_go = 1'b0;
  endtask

  function automatic logic [1:0] exp_lat(input logic [7:0] c, input logic [2:0] p);
    logic [1:0] f;
    f = c[5] ? c[7:6] : (p[0] ? set_m[p>>1][21:20] : set_m[p>>1][5:4]);
    if (c[3]) f[0] = 1'b0;
    return f;
  endfunction

  function automatic logic [31:0] dflt(input int a);
    return (a >= 5 && a <= 8) ? 32'h0100_0000 : 32'h0;
  endfunction

  initial begin
    #(8 * 150000);
    total++; bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) set_m[i] = '0;
    ptr_m = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset defaults, R6 unmapped addresses
    chk("R1 latch", {30'h0, latch_o}, 32'h0);
    for (int a = 0; a < 16; a++) begin
      rd(4'(a), rv);
      chk(a > 12 ? "R6 unmapped" : "R1 default", rv, dflt(a));
    end

    // R6 write/readback across all data words
    for (int a = 1; a <= 12; a++) wr(4'(a), 32'h1357_9BDF ^ (32'(a) * 32'h0101_0101));
    for (int a = 1; a <= 12; a++) begin
      rd(4'(a), rv);
      chk("R6 readback", rv, 32'h1357_9BDF ^ (32'(a) * 32'h0101_0101));
    end
    // R6 read data holds without a strobe
    repeat (2) @(negedge clk);
    chk("R6 hold", rdata, 32'h1357_9BDF ^ (32'd12 * 32'h0101_0101));

    // R8 pointer sweep with distinct latch fields
    for (int s = 0; s < 4; s++) begin
      set_m[s] = 32'h0;
      set_m[s][5:4]   = 2'((2*s) % 4);
      set_m[s][21:20] = 2'((3*s + 1) % 4);
      set_m[s][31:24] = 8'(s);
      wr(4'(9 + s), set_m[s]);
    end
    for (int p = 0; p < 8; p++) begin
      conv(3'(p));
      ptr_m = 3'(p);
      chk("R8 select", {30'h0, latch_o}, {30'h0, exp_lat(8'h00, ptr_m)});
    end
    // R8 conv_sel without conv_go has no effect
    conv_sel = 3'd2;
    repeat (2) @(negedge clk);
    chk("R8 no strobe", {30'h0, latch_o}, {30'h0, exp_lat(8'h00, ptr_m)});

    // R11 registered update after setup rewrite (pointer 7: word 3 upper)
    set_m[3][21:20] = ~set_m[3][21:20];
    wr(4'd12, set_m[3]);
    chk("R11 old value", {30'h0, latch_o}, {30'h0, ~exp_lat(8'h00, ptr_m)});
    @(negedge clk);
    chk("R11 new value", {30'h0, latch_o}, {30'h0, exp_lat(8'h00, ptr_m)});

    // R7 R9 R10 configuration sweep
    for (int v = 0; v < 256; v += 2) begin
      wr(4'd0, {24'hABCDEF, 8'(v)});
      @(negedge clk);
      chk("R9 R10 latch", {30'h0, latch_o}, {30'h0, exp_lat(8'(v), ptr_m)});
      chk("R7 pins", {29'h0, short_o, guard_o, vref_o}, {29'h0, v[2], v[3], v[4]});
      rd(4'd0, rv);
      chk("R7 R3 cfg read", rv, {24'h0, 8'(v) & 8'hFC});
    end

    // R9 fixed latch holds across pointer changes
    wr(4'd0, 32'h0000_00A0);
    for (int p = 0; p < 8; p++) begin
      conv(3'(p));
      ptr_m = 3'(p);
      chk("R9 fixed", {30'h0, latch_o}, 32'h2);
    end

    // R2 soft reset
    wr(4'd0, 32'hFFFF_FFFF);
    @(negedge clk);
    chk("R2 pins", {27'h0, latch_o, short_o, guard_o, vref_o}, 32'h0);
    rd(4'd0, rv);
    chk("R3 first read", rv, 32'h3);
    rd(4'd0, rv);
    chk("R3 second read", rv, 32'h1);
    // R5 writes ignored while pending
    wr(4'd2, 32'hDEAD_BEEF);
    wr(4'd6, 32'hDEAD_BEEF);
    wr(4'd10, 32'hDEAD_BEEF);
    for (int a = 1; a <= 12; a++) begin
      rd(4'(a), rv);
      chk("R5 R2 default", rv, dflt(a));
    end
    // R4 exit write ignores other bits
    wr(4'd0, 32'h0000_00FC);
    rd(4'd0, rv);
    chk("R4 exit", rv, 32'h0);
    @(negedge clk);
    chk("R4 pins", {27'h0, latch_o, short_o, guard_o, vref_o}, 32'h0);
    wr(4'd0, 32'h0000_0014);
    rd(4'd0, rv);
    chk("R4 normal", rv, 32'h14);
    wr(4'd3, 32'h0BAD_F00D);
    rd(4'd3, rv);
    chk("R5 unlocked", rv, 32'h0BAD_F00D);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule